// File: doc/BRIEF.md
# UART Receive Front End

This block sits between the receive line of a UART and its data shifter. It chooses the line to listen to: either the external receive pin or, in loopback, the local transmit line. It can invert that line so that the logic after it always sees an idle level of 1. The line then passes through a synchronizer, and the block detects its edges.

Two hardware-managed functions run on the conditioned line. The first is a sleep wake-up detector. While the system sleeps, a falling edge raises a single-cycle wake interrupt. The detector clears its own enable on the rising edge that follows.

The second is an automatic baud measurement. It times the first four low-going periods of a 0x55 sync character, converts the count into a baud-generator divisor and then clears its own enable. A counter overflow cancels the measurement and leaves the divisor unchanged.

Top module: `uart_rx_frontend`

## Requirements
- R1: While `enable_i` is low, `rx_o` reads 1 one edge later. Both `wake_en_o` and `abaud_en_o` read 0, and the set pulses `wake_set_i` and `abaud_set_i` are ignored.
- R2: With `loopback_i` high, the receive path takes `tx_loc_i`, and `rx_pin_i` has no effect on `rx_o`. With `loopback_i` low, it takes `rx_pin_i`.
- R3: With `invert_i` high, the selected line is inverted, so an external idle level of 0 appears as 1 on `rx_o`.
- R4: A level change on the selected line reaches `rx_o` after two rising clock edges.
- R5: A falling edge on the conditioned line produces a one-cycle `wake_irq_o` pulse, but only while `sleep_i` is high and `wake_en_o` is 1. Only one pulse is produced per armed wake.
- R6: After a wake pulse, `wake_en_o` stays 1 until the next rising edge of the conditioned line, and then it clears.
- R7: Let T be the number of clocks from the first to the fifth falling edge of the sync character. Once `abaud_en_o` is set, the divisor becomes floor(T/128) - 1, clamped at 0.
- R8: With `hi_speed_i` high, the divisor becomes floor(T/32) - 1, clamped at 0.
- R9: A completed measurement gives a one-cycle `abaud_done_o` pulse, updates `div_o` in that same cycle and clears `abaud_en_o`. `div_o` changes at no other time.
- R10: If the measurement counter reaches 2^CNT_W - 1 before the fifth falling edge, `abaud_en_o` clears without an `abaud_done_o` pulse, and `div_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Module enable |
| invert_i | input | 1 | Receive polarity inversion (idle level 0 when set) |
| loopback_i | input | 1 | Take the local transmit line as the receive source |
| hi_speed_i | input | 1 | Divisor for the 4x oversampling generator instead of 16x |
| sleep_i | input | 1 | System sleep indication |
| wake_set_i | input | 1 | One-cycle request that sets the wake enable |
| abaud_set_i | input | 1 | One-cycle request that sets the auto-baud enable |
| rx_pin_i | input | 1 | External receive pin |
| tx_loc_i | input | 1 | Local transmit line |
| rx_o | output | 1 | Conditioned, synchronized receive line (idle 1) |
| wake_en_o | output | 1 | Wake enable status, cleared by hardware |
| wake_irq_o | output | 1 | One-cycle wake interrupt |
| abaud_en_o | output | 1 | Auto-baud enable status, cleared by hardware |
| abaud_done_o | output | 1 | One-cycle measurement-complete event |
| div_o | output | DIV_W | Measured baud-generator divisor |

## Verification
The bench builds the block with CNT_W = 10 and DIV_W = 8, and leaves the oversampling factors at 16 and 4. The 10-bit counter lets a 160-clock bit time overflow the measurement, so the abort path is exercised within a few thousand cycles. Bit times of 64 and 48 clocks complete in both divisor modes, and an 8-clock bit time reaches the zero clamp. Wake and measurement events go through a queue of expected outcomes, so any unexpected or missing pulse is reported.

// File: rtl/uart_rx_fe_pkg.sv
package uart_rx_fe_pkg;
  typedef enum logic [1:0] {
    AB_OFF   = 2'd0,
    AB_WAIT  = 2'd1,
    AB_COUNT = 2'd2
  } ab_state_e;

  localparam int unsigned SYNC_FALLS = 5;
  localparam int unsigned SYNC_BITS  = 8;
endpackage

// File: rtl/uart_rx_cond.sv
module uart_rx_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic invert_i,
  input  logic loopback_i,
  input  logic rx_pin_i,
  input  logic tx_loc_i,
  output logic rx_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              src;

  assign src = (loopback_i ? tx_loc_i : rx_pin_i) ^ invert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else if (!enable_i) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], src};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rx_o   = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
  assign rise_o = ~prev_q & sync_q[STAGES-1];

  // R1
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> rx_o);
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic set_i,
  input  logic sleep_i,
  input  logic fall_i,
  input  logic rise_i,
  output logic en_o,
  output logic irq_o
);
  logic en_q, armed_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!enable_i) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (set_i) en_q <= 1'b1;
      if (en_q && !armed_q && sleep_i && fall_i) begin
        armed_q <= 1'b1;
        irq_q   <= 1'b1;
      end else if (armed_q && rise_i) begin
        armed_q <= 1'b0;
        en_q    <= 1'b0;
      end
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  // R5
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R5
  wake_in_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(sleep_i));
  // R6
  wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> (!$past(enable_i) || $past(rise_i)));
endmodule

// File: rtl/uart_rx_autobaud.sv
module uart_rx_autobaud
  import uart_rx_fe_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned OVS_LO = 16,
  parameter int unsigned OVS_HI = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             set_i,
  input  logic             hi_speed_i,
  input  logic             fall_i,
  output logic             en_o,
  output logic             done_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned SH_LO  = $clog2(SYNC_BITS * OVS_LO);
  localparam int unsigned SH_HI  = $clog2(SYNC_BITS * OVS_HI);
  localparam int unsigned FALL_W = $clog2(SYNC_FALLS);
  localparam logic [FALL_W-1:0] LAST_FALL = FALL_W'(SYNC_FALLS - 2);

  ab_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, quo, div_calc;
  logic [FALL_W-1:0] falls_q;
  logic              done_q;
  logic [DIV_W-1:0]  div_q;

  assign quo      = hi_speed_i ? (cnt_q >> SH_HI) : (cnt_q >> SH_LO);
  assign div_calc = (quo == '0) ? '0 : quo - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= AB_OFF;
      cnt_q   <= '0;
      falls_q <= '0;
      done_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!enable_i) begin
        state_q <= AB_OFF;
      end else begin
        unique case (state_q)
          AB_OFF: if (set_i) state_q <= AB_WAIT;
          AB_WAIT: if (fall_i) begin
            state_q <= AB_COUNT;
            cnt_q   <= CNT_W'(1);
            falls_q <= '0;
          end
          AB_COUNT: begin
            if (fall_i && falls_q == LAST_FALL) begin
              state_q <= AB_OFF;
              div_q   <= DIV_W'(div_calc);
              done_q  <= 1'b1;
            end else if (&cnt_q) begin
              state_q <= AB_OFF;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (fall_i) falls_q <= falls_q + 1'b1;
            end
          end
          default: state_q <= AB_OFF;
        endcase
      end
    end
  end

  assign en_o   = (state_q != AB_OFF);
  assign done_o = done_q;
  assign div_o  = div_q;

  // R9
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> state_q == AB_OFF);
  // R9
  div_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> done_q);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/uart_rx_frontend.sv
module uart_rx_frontend
  import uart_rx_fe_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned OVS_LO = 16,
  parameter int unsigned OVS_HI = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             invert_i,
  input  logic             loopback_i,
  input  logic             hi_speed_i,
  input  logic             sleep_i,
  input  logic             wake_set_i,
  input  logic             abaud_set_i,
  input  logic             rx_pin_i,
  input  logic             tx_loc_i,
  output logic             rx_o,
  output logic             wake_en_o,
  output logic             wake_irq_o,
  output logic             abaud_en_o,
  output logic             abaud_done_o,
  output logic [DIV_W-1:0] div_o
);
  logic fall, rise;

  uart_rx_cond #(.STAGES(STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .invert_i   (invert_i),
    .loopback_i (loopback_i),
    .rx_pin_i   (rx_pin_i),
    .tx_loc_i   (tx_loc_i),
    .rx_o       (rx_o),
    .fall_o     (fall),
    .rise_o     (rise)
  );

  uart_rx_wake u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .set_i    (wake_set_i),
    .sleep_i  (sleep_i),
    .fall_i   (fall),
    .rise_i   (rise),
    .en_o     (wake_en_o),
    .irq_o    (wake_irq_o)
  );

  uart_rx_autobaud #(
    .CNT_W  (CNT_W),
    .DIV_W  (DIV_W),
    .OVS_LO (OVS_LO),
    .OVS_HI (OVS_HI)
  ) u_abaud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .set_i      (abaud_set_i),
    .hi_speed_i (hi_speed_i),
    .fall_i     (fall),
    .en_o       (abaud_en_o),
    .done_o     (abaud_done_o),
    .div_o      (div_o)
  );

  // R1
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> !wake_en_o && !abaud_en_o && !wake_irq_o && !abaud_done_o);
endmodule

// File: tb/tb_uart_rx_frontend.sv
module tb_uart_rx_frontend;
  localparam int unsigned CNT_W = 10;
  localparam int unsigned DIV_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable_i = 0, invert_i = 0, loopback_i = 0, hi_speed_i = 0, sleep_i = 0;
  logic wake_set_i = 0, abaud_set_i = 0, rx_pin_i = 1, tx_loc_i = 1;
  logic rx_o, wake_en_o, wake_irq_o, abaud_en_o, abaud_done_o;
  logic [DIV_W-1:0] div_o;

  int checks = 0, errors = 0;

  typedef struct {int kind; int div;} ev_t; // kind 0 wake, 1 baud done
  ev_t exp_q[$];

  always #2 clk = ~clk;

  uart_rx_frontend #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .invert_i(invert_i),
    .loopback_i(loopback_i), .hi_speed_i(hi_speed_i), .sleep_i(sleep_i),
    .wake_set_i(wake_set_i), .abaud_set_i(abaud_set_i), .rx_pin_i(rx_pin_i),
    .tx_loc_i(tx_loc_i), .rx_o(rx_o), .wake_en_o(wake_en_o), .wake_irq_o(wake_irq_o),
    .abaud_en_o(abaud_en_o), .abaud_done_o(abaud_done_o), .div_o(div_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // logical line level through the currently selected source and polarity
  task automatic line(input logic v);
    if (loopback_i) tx_loc_i = v ^ invert_i;
    else            rx_pin_i = v ^ invert_i;
  endtask

  task automatic pulse_wake();
    wake_set_i = 1; tick(1); wake_set_i = 0;
  endtask

  task automatic pulse_abaud();
    abaud_set_i = 1; tick(1); abaud_set_i = 0;
  endtask

  // 0x55 framed: start, LSB first data, stop
  task automatic send_sync(input int bt);
    logic [9:0] fr = {1'b1, 8'h55, 1'b0};
    for (int b = 0; b < 10; b++) begin
      line(fr[b]);
      tick(bt);
    end
    tick(4);
  endtask

  task automatic expect_done(input int d);
    ev_t e; e.kind = 1; e.div = d; exp_q.push_back(e);
  endtask

  task automatic expect_wake();
    ev_t e; e.kind = 0; e.div = 0; exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && (wake_irq_o || abaud_done_o)) begin
      ev_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5/R9 unexpected event actual wake=%0d done=%0d expected none",
                 wake_irq_o, abaud_done_o);
      end else begin
        e = exp_q.pop_front();
        if (e.kind == 0 && !wake_irq_o) begin
          errors++;
          $display("FAIL R5 actual wake=0 expected wake=1");
        end else if (e.kind == 1 && (!abaud_done_o || int'(div_o) != e.div)) begin
          errors++;
          $display("FAIL R7/R8 actual div=%0d expected div=%0d", div_o, e.div);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1;
    tick(1);
    chk("R1 reset rx", rx_o, 1);
    chk("R1 reset wake_en", wake_en_o, 0);
    chk("R1 reset abaud_en", abaud_en_o, 0);
    chk("R1 reset div", div_o, 0);

    // R1 disabled ignores everything
    rx_pin_i = 0; pulse_wake(); pulse_abaud(); tick(3);
    chk("R1 rx idle when off", rx_o, 1);
    chk("R1 wake set ignored", wake_en_o, 0);
    chk("R1 abaud set ignored", abaud_en_o, 0);
    rx_pin_i = 1;

    // R4 latency
    enable_i = 1; tick(3);
    rx_pin_i = 0;
    @(posedge clk); @(negedge clk);
    chk("R4 one edge still high", rx_o, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 two edges low", rx_o, 0);
    rx_pin_i = 1; tick(3);
    chk("R4 back high", rx_o, 1);

    // R3 inversion
    invert_i = 1; rx_pin_i = 0; tick(3);
    chk("R3 inverted idle", rx_o, 1);
    rx_pin_i = 1; tick(3);
    chk("R3 inverted active", rx_o, 0);
    rx_pin_i = 0; invert_i = 0; rx_pin_i = 1; tick(3);

    // R2 loopback
    loopback_i = 1; tx_loc_i = 0; rx_pin_i = 1; tick(3);
    chk("R2 loopback follows tx", rx_o, 0);
    rx_pin_i = 0; tick(3);
    chk("R2 pin ignored in loopback", rx_o, 0);
    tx_loc_i = 1; tick(3);
    chk("R2 loopback tx high", rx_o, 1);
    loopback_i = 0; rx_pin_i = 1; tick(3);
    chk("R2 pin selected", rx_o, 1);

    // R5 no wake outside sleep
    pulse_wake(); tick(1);
    chk("R5 wake_en set", wake_en_o, 1);
    line(0); tick(6); line(1); tick(6);
    chk("R5 no sleep keeps enable", wake_en_o, 1);

    // R5 R6 wake in sleep
    sleep_i = 1; expect_wake();
    line(0); tick(6);
    chk("R6 enable held until rise", wake_en_o, 1);
    line(0); tick(4);
    line(1); tick(6);
    chk("R6 cleared on rise", wake_en_o, 0);
    line(0); tick(4); line(1); tick(4);
    sleep_i = 0;
    chk("R5 event consumed", exp_q.size(), 0);

    // R1 disable clears wake enable
    pulse_wake(); tick(1);
    enable_i = 0; tick(2);
    chk("R1 disable clears wake_en", wake_en_o, 0);
    enable_i = 1; tick(3);

    // R7 normal mode, bit time 64 -> 512/128-1 = 3
    pulse_abaud(); tick(1);
    chk("R9 abaud_en set", abaud_en_o, 1);
    expect_done(3); send_sync(64);
    chk("R9 abaud_en cleared", abaud_en_o, 0);
    chk("R7 div", div_o, 3);
    chk("R9 done seen", exp_q.size(), 0);

    // R9 later character leaves div alone
    send_sync(32);
    chk("R9 div kept without enable", div_o, 3);

    // R8 high speed, 64 -> 512/32-1 = 15
    hi_speed_i = 1; pulse_abaud();
    expect_done(15); send_sync(64);
    chk("R8 div hi speed", div_o, 15);

    // R8 via loopback and inversion, 48 -> 384/32-1 = 11
    loopback_i = 1; invert_i = 1; tx_loc_i = 0; tick(4);
    pulse_abaud();
    expect_done(11); send_sync(48);
    chk("R8 div loopback inverted", div_o, 11);
    loopback_i = 0; invert_i = 0; rx_pin_i = 1; tick(4);

    // R10 overflow, 160 -> 1280 > 1023
    hi_speed_i = 0; pulse_abaud();
    send_sync(160);
    chk("R10 enable cleared on overflow", abaud_en_o, 0);
    chk("R10 div unchanged", div_o, 11);
    chk("R10 no done", exp_q.size(), 0);

    // R7 clamp, 8 -> 64/128 = 0 -> 0
    pulse_abaud();
    expect_done(0); send_sync(8);
    chk("R7 clamp zero", div_o, 0);
    tick(10);
    chk("R9 queue drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule